// File: doc/BRIEF.md
# UART Host Register Bank Decoder

This block is the processor-side register front end of a UART whose transmit and receive paths can run either with single-byte buffering or with 16-entry byte FIFOs. A host reaches eight byte-wide locations through a 3-bit offset, a chip select and separate read and write strobes. Every cycle in which the chip select and a strobe are both high counts as one access. Read data is combinational and is valid in the same cycle as the read strobe. Outside a read access it is zero.

The block holds the interrupt enable, line configuration, modem control, scratch and 16-bit divisor registers. It also holds the FIFO mode and receive trigger settings. It presents all of these as outputs to the serial engine and to the interrupt logic. Line status, modem status and interrupt identification arrive as inputs and are only read. A bank-select bit in the line configuration register decides what offsets 0 and 1 reach. When it is clear, they reach the data path and the interrupt enable register. When it is set, they reach the two divisor bytes. Accesses to the data location produce push and pop strobes for external FIFOs. After reset the block is in single-buffer character mode.

Top module: `uart_hostregs`

## Requirements
- R1: After reset, these registers read 0: interrupt enable, line configuration, modem control, scratch and divisor. After reset, FIFO mode is off, read bits 7:6 of offset 2 are 0, and `rxTrigBytes` is 1.
- R2: With the bank-select bit clear, a read of offset 0 returns `rxData` and raises `rxPop` in that cycle only. A write of offset 0 raises `txPush` in that cycle only, and the byte to push is `wrData`.
- R3: With the bank-select bit clear, offset 1 is the read/write interrupt enable register. Its value drives `intEnableOut`.
- R4: With the bank-select bit set, offset 0 is the low divisor byte and offset 1 is the high divisor byte. Both bytes are read/write and drive `divisorOut`, and accesses to these offsets raise neither `txPush` nor `rxPop`.
- R5: Offset 3 is the read/write line configuration register. Bit 7 is the bank-select bit, bits 1:0 drive `wordLen`, bit 2 drives `stopBits`, and bits 5:3 drive `parityCfg`.
- R6: A read of offset 2 returns `intIdent[5:0]` in bits 5:0. Bits 7:6 read 2'b11 in FIFO mode and 2'b00 in character mode, whatever the input carries in those bits.
- R7: A write of offset 2 sets FIFO mode from bit 0. It sets the receive trigger from bits 7:6, where codes 0, 1, 2 and 3 give `rxTrigBytes` values of 1, 4, 8 and 14. Bit 1 raises `rxFifoClr` and bit 2 raises `txFifoClr`, each for the write cycle only.
- R8: Offsets 4, 5, 6 and 7 are modem control (read/write), line status (reads `lineStatus`), modem status (reads `modemStatus`) and scratch (read/write). They decode the same way whatever the value of the bank-select bit.
- R9: A write to offset 5 or offset 6 changes no register.
- R10: While `csel` is low, strobes cause no register change, no push, no pop and no FIFO clear pulse, and `rdData` is 0.
- R11: `modemCtlOut` always carries the modem control register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous |
| csel | input | 1 | Chip select |
| rdStb | input | 1 | Read strobe |
| wrStb | input | 1 | Write strobe |
| addr | input | 3 | Register offset |
| wrData | input | 8 | Write data; also the byte to push into the transmit FIFO |
| rdData | output | 8 | Read data (combinational) |
| rxData | input | 8 | Head byte of the receive FIFO |
| lineStatus | input | 8 | Line status value |
| modemStatus | input | 8 | Modem status value |
| intIdent | input | 8 | Interrupt identification value |
| txPush | output | 1 | Transmit FIFO push strobe |
| rxPop | output | 1 | Receive FIFO pop strobe |
| rxFifoClr | output | 1 | Receive FIFO clear pulse |
| txFifoClr | output | 1 | Transmit FIFO clear pulse |
| fifoEn | output | 1 | FIFO mode enable |
| rxTrigBytes | output | 5 | Receive trigger level in bytes |
| divisorOut | output | 16 | Baud divisor |
| wordLen | output | 2 | Word length code |
| stopBits | output | 1 | Stop bit select |
| parityCfg | output | 3 | Parity setting |
| intEnableOut | output | 8 | Interrupt enable register |
| modemCtlOut | output | 8 | Modem control register |

## Verification
The bench toggles the bank-select bit back and forth. It checks that offsets 0 and 1 switch between the data and enable registers and the divisor bytes, and that the interrupt enable and divisor values are kept across each switch. A decoder that ignored the bit would write over the enable register when the divisor is loaded, or would pop the receive FIFO during a divisor read. The bench also writes to the read-only status offsets and drives strobes with the chip select low, then reads every writable register back. A decoder that let either access through would corrupt the scratch or modem register. At offset 2 the bench checks that a write reaches the FIFO control settings and that a read returns identification with bits 7:6 forced according to the mode. It also checks that the FIFO clear pulses last only one cycle. Swapping the read and write targets at this offset, or latching the clear bits, would break those checks.

// File: rtl/uart_hostregs_pkg.sv
package uart_hostregs_pkg;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam int DIV_BYTES = 2;
  localparam int DIV_W     = DIV_BYTES * DATA_W;
  localparam int TRIG_W    = 5;
  localparam int BANK_BIT  = DATA_W - 1;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_IE    = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_IDENT = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_LINE  = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_MODEM = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_LSTAT = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_MSTAT = 3'd6;
  localparam logic [ADDR_W-1:0] OFS_SCR   = 3'd7;

  typedef enum logic [3:0] {
    RD_NONE, RD_RXBUF, RD_IE, RD_DIV0, RD_DIV1, RD_IDENT,
    RD_LINE, RD_MODEM, RD_LSTAT, RD_MSTAT, RD_SCRATCH
  } rdSel_e;

  typedef struct packed {
    logic                 wrIe;
    logic [DIV_BYTES-1:0] wrDiv;
    logic                 wrFifoCtl;
    logic                 wrLine;
    logic                 wrModem;
    logic                 wrScratch;
    logic                 push;
    logic                 pop;
    rdSel_e               rdSel;
  } hostStrobes_t;
endpackage

// File: rtl/uart_hostregs_ctrl.sv
module uart_hostregs_ctrl
  import uart_hostregs_pkg::*;
(
  input  logic              csel,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bankSel,
  output hostStrobes_t      stb
);
  logic rdAcc;
  logic wrAcc;

  assign rdAcc = csel & rdStb;
  assign wrAcc = csel & wrStb;

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    unique case (addr)
      OFS_DATA: begin
        if (bankSel) begin
          stb.wrDiv[0] = wrAcc;
          if (rdAcc) stb.rdSel = RD_DIV0;
        end else begin
          stb.push = wrAcc;
          stb.pop  = rdAcc;
          if (rdAcc) stb.rdSel = RD_RXBUF;
        end
      end
      OFS_IE: begin
        if (bankSel) begin
          stb.wrDiv[1] = wrAcc;
          if (rdAcc) stb.rdSel = RD_DIV1;
        end else begin
          stb.wrIe = wrAcc;
          if (rdAcc) stb.rdSel = RD_IE;
        end
      end
      OFS_IDENT: begin
        stb.wrFifoCtl = wrAcc;
        if (rdAcc) stb.rdSel = RD_IDENT;
      end
      OFS_LINE: begin
        stb.wrLine = wrAcc;
        if (rdAcc) stb.rdSel = RD_LINE;
      end
      OFS_MODEM: begin
        stb.wrModem = wrAcc;
        if (rdAcc) stb.rdSel = RD_MODEM;
      end
      OFS_LSTAT: if (rdAcc) stb.rdSel = RD_LSTAT;
      OFS_MSTAT: if (rdAcc) stb.rdSel = RD_MSTAT;
      OFS_SCR: begin
        stb.wrScratch = wrAcc;
        if (rdAcc) stb.rdSel = RD_SCRATCH;
      end
      default: stb.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/uart_hostregs_dpath.sv
module uart_hostregs_dpath
  import uart_hostregs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  hostStrobes_t      stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] rxData,
  input  logic [DATA_W-1:0] lineStatus,
  input  logic [DATA_W-1:0] modemStatus,
  input  logic [DATA_W-1:0] intIdent,
  output logic [DATA_W-1:0] rdData,
  output logic              rxFifoClr,
  output logic              txFifoClr,
  output logic              fifoEn,
  output logic [TRIG_W-1:0] rxTrigBytes,
  output logic [DIV_W-1:0]  divisorOut,
  output logic [DATA_W-1:0] lineCfg,
  output logic [DATA_W-1:0] intEnable,
  output logic [DATA_W-1:0] modemCtl
);
  logic [DATA_W-1:0] scratch;
  logic [1:0]        trigCode;
  logic [DATA_W-1:0] identRead;

  function automatic logic [TRIG_W-1:0] trigToBytes(input logic [1:0] code);
    unique case (code)
      2'd0:    trigToBytes = TRIG_W'(1);
      2'd1:    trigToBytes = TRIG_W'(4);
      2'd2:    trigToBytes = TRIG_W'(8);
      default: trigToBytes = TRIG_W'(14);
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] nextByte(input logic we, input logic [DATA_W-1:0] cur,
                                                 input logic [DATA_W-1:0] din);
    nextByte = we ? din : cur;
  endfunction

  genvar gi;
  generate
    for (gi = 0; gi < DIV_BYTES; gi++) begin : g_divByte
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) divisorOut[gi*DATA_W +: DATA_W] <= '0;
        else divisorOut[gi*DATA_W +: DATA_W] <=
               nextByte(stb.wrDiv[gi], divisorOut[gi*DATA_W +: DATA_W], wrData);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEnable <= '0;
      lineCfg   <= '0;
      modemCtl  <= '0;
      scratch   <= '0;
      fifoEn    <= 1'b0;
      trigCode  <= 2'd0;
    end else begin
      intEnable <= nextByte(stb.wrIe, intEnable, wrData);
      lineCfg   <= nextByte(stb.wrLine, lineCfg, wrData);
      modemCtl  <= nextByte(stb.wrModem, modemCtl, wrData);
      scratch   <= nextByte(stb.wrScratch, scratch, wrData);
      if (stb.wrFifoCtl) begin
        fifoEn   <= wrData[0];
        trigCode <= wrData[DATA_W-1 -: 2];
      end
    end
  end

  assign rxTrigBytes = trigToBytes(trigCode);
  assign rxFifoClr   = stb.wrFifoCtl & wrData[1];
  assign txFifoClr   = stb.wrFifoCtl & wrData[2];
  assign identRead   = {{2{fifoEn}}, intIdent[DATA_W-3:0]};

  always_comb begin
    unique case (stb.rdSel)
      RD_RXBUF:   rdData = rxData;
      RD_IE:      rdData = intEnable;
      RD_DIV0:    rdData = divisorOut[0 +: DATA_W];
      RD_DIV1:    rdData = divisorOut[DATA_W +: DATA_W];
      RD_IDENT:   rdData = identRead;
      RD_LINE:    rdData = lineCfg;
      RD_MODEM:   rdData = modemCtl;
      RD_LSTAT:   rdData = lineStatus;
      RD_MSTAT:   rdData = modemStatus;
      RD_SCRATCH: rdData = scratch;
      default:    rdData = '0;
    endcase
  end
endmodule

// File: rtl/uart_hostregs.sv
module uart_hostregs
  import uart_hostregs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csel,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] rxData,
  input  logic [DATA_W-1:0] lineStatus,
  input  logic [DATA_W-1:0] modemStatus,
  input  logic [DATA_W-1:0] intIdent,
  output logic              txPush,
  output logic              rxPop,
  output logic              rxFifoClr,
  output logic              txFifoClr,
  output logic              fifoEn,
  output logic [TRIG_W-1:0] rxTrigBytes,
  output logic [DIV_W-1:0]  divisorOut,
  output logic [1:0]        wordLen,
  output logic              stopBits,
  output logic [2:0]        parityCfg,
  output logic [DATA_W-1:0] intEnableOut,
  output logic [DATA_W-1:0] modemCtlOut
);
  hostStrobes_t      stb;
  logic [DATA_W-1:0] lineCfg;

  uart_hostregs_ctrl ctrl_i (
    .csel    (csel),
    .rdStb   (rdStb),
    .wrStb   (wrStb),
    .addr    (addr),
    .bankSel (lineCfg[BANK_BIT]),
    .stb     (stb)
  );

  uart_hostregs_dpath dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrData      (wrData),
    .rxData      (rxData),
    .lineStatus  (lineStatus),
    .modemStatus (modemStatus),
    .intIdent    (intIdent),
    .rdData      (rdData),
    .rxFifoClr   (rxFifoClr),
    .txFifoClr   (txFifoClr),
    .fifoEn      (fifoEn),
    .rxTrigBytes (rxTrigBytes),
    .divisorOut  (divisorOut),
    .lineCfg     (lineCfg),
    .intEnable   (intEnableOut),
    .modemCtl    (modemCtlOut)
  );

  assign txPush    = stb.push;
  assign rxPop     = stb.pop;
  assign wordLen   = lineCfg[1:0];
  assign stopBits  = lineCfg[2];
  assign parityCfg = lineCfg[5:3];
endmodule

// File: rtl/uart_hostregs_chk.sv
module uart_hostregs_chk
  import uart_hostregs_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              csel,
  input logic              rdStb,
  input logic              wrStb,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              txPush,
  input logic              rxPop,
  input logic              rxFifoClr,
  input logic              txFifoClr,
  input logic              fifoEn,
  input logic [TRIG_W-1:0] rxTrigBytes,
  input logic [DIV_W-1:0]  divisorOut,
  input logic [DATA_W-1:0] intEnableOut,
  input logic [DATA_W-1:0] modemCtlOut
);
  AST_POP_NEEDS_READ: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> (csel && rdStb && addr == OFS_DATA && !txPush)); // R2

  AST_PUSH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    txPush |-> (csel && wrStb && addr == OFS_DATA)); // R2

  AST_DIV_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !(csel && wrStb && (addr == OFS_DATA || addr == OFS_IE)) |=> $stable(divisorOut)); // R4

  AST_TRIG_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (rxTrigBytes == 5'd1 || rxTrigBytes == 5'd4 || rxTrigBytes == 5'd8 || rxTrigBytes == 5'd14)); // R7

  AST_CLR_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (rxFifoClr || txFifoClr) |-> (csel && wrStb && addr == OFS_IDENT)); // R7

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (csel && wrStb && (addr == OFS_LSTAT || addr == OFS_MSTAT)) |=>
      ($stable(intEnableOut) && $stable(modemCtlOut) && $stable(divisorOut) && $stable(fifoEn))); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !csel |-> (rdData == '0 && !txPush && !rxPop && !rxFifoClr && !txFifoClr)); // R10

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !csel |=> ($stable(modemCtlOut) && $stable(intEnableOut) && $stable(fifoEn))); // R10
endmodule

bind uart_hostregs uart_hostregs_chk chk_i (.*);

// File: tb/uart_hostregs_tb_top.sv
module uart_hostregs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] LSTAT_V = 8'h60;
  localparam logic [7:0] MSTAT_V = 8'hB0;
  localparam logic [7:0] IDENT_V = 8'hC1;
  localparam logic [7:0] RXBUF_V = 8'h5A;

  typedef struct packed {
    logic       wr;
    logic [2:0] a;
    logic [7:0] d;
    logic [7:0] exp;
    logic       push;
    logic       pop;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 32;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 3'd0, 8'h77, 8'h00, 1'b1, 1'b0, 4'd2},  // R2 push
    '{1'b1, 3'd3, 8'h03, 8'h00, 1'b0, 1'b0, 4'd5},
    '{1'b0, 3'd3, 8'h00, 8'h03, 1'b0, 1'b0, 4'd5},  // R5 readback
    '{1'b1, 3'd1, 8'h0F, 8'h00, 1'b0, 1'b0, 4'd3},
    '{1'b0, 3'd1, 8'h00, 8'h0F, 1'b0, 1'b0, 4'd3},  // R3
    '{1'b1, 3'd7, 8'hA5, 8'h00, 1'b0, 1'b0, 4'd8},
    '{1'b0, 3'd7, 8'h00, 8'hA5, 1'b0, 1'b0, 4'd8},  // R8 scratch
    '{1'b1, 3'd4, 8'h13, 8'h00, 1'b0, 1'b0, 4'd8},
    '{1'b0, 3'd4, 8'h00, 8'h13, 1'b0, 1'b0, 4'd8},  // R8 modem ctl
    '{1'b0, 3'd5, 8'h00, LSTAT_V, 1'b0, 1'b0, 4'd8},
    '{1'b0, 3'd6, 8'h00, MSTAT_V, 1'b0, 1'b0, 4'd8},
    '{1'b1, 3'd3, 8'h83, 8'h00, 1'b0, 1'b0, 4'd4},  // bank bit set
    '{1'b1, 3'd0, 8'h34, 8'h00, 1'b0, 1'b0, 4'd4},  // R4 no push
    '{1'b1, 3'd1, 8'h12, 8'h00, 1'b0, 1'b0, 4'd4},
    '{1'b0, 3'd0, 8'h00, 8'h34, 1'b0, 1'b0, 4'd4},  // R4 no pop
    '{1'b0, 3'd1, 8'h00, 8'h12, 1'b0, 1'b0, 4'd4},
    '{1'b0, 3'd7, 8'h00, 8'hA5, 1'b0, 1'b0, 4'd8},  // R8 bank-independent
    '{1'b0, 3'd5, 8'h00, LSTAT_V, 1'b0, 1'b0, 4'd8},
    '{1'b0, 3'd3, 8'h00, 8'h83, 1'b0, 1'b0, 4'd5},
    '{1'b1, 3'd3, 8'h03, 8'h00, 1'b0, 1'b0, 4'd5},  // bank bit clear
    '{1'b0, 3'd1, 8'h00, 8'h0F, 1'b0, 1'b0, 4'd3},  // R3 kept
    '{1'b0, 3'd0, 8'h00, RXBUF_V, 1'b0, 1'b1, 4'd2}, // R2 pop
    '{1'b1, 3'd5, 8'hFF, 8'h00, 1'b0, 1'b0, 4'd9},  // R9
    '{1'b1, 3'd6, 8'hFF, 8'h00, 1'b0, 1'b0, 4'd9},
    '{1'b0, 3'd5, 8'h00, LSTAT_V, 1'b0, 1'b0, 4'd9},
    '{1'b0, 3'd6, 8'h00, MSTAT_V, 1'b0, 1'b0, 4'd9},
    '{1'b0, 3'd7, 8'h00, 8'hA5, 1'b0, 1'b0, 4'd9},
    '{1'b0, 3'd4, 8'h00, 8'h13, 1'b0, 1'b0, 4'd9},
    '{1'b0, 3'd1, 8'h00, 8'h0F, 1'b0, 1'b0, 4'd9},
    '{1'b0, 3'd2, 8'h00, 8'h01, 1'b0, 1'b0, 4'd6},  // R6 char mode
    '{1'b1, 3'd2, 8'hC1, 8'h00, 1'b0, 1'b0, 4'd7},
    '{1'b0, 3'd2, 8'h00, 8'hC1, 1'b0, 1'b0, 4'd6}   // R6 FIFO mode
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csel = 1'b0, rdStb = 1'b0, wrStb = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic txPush, rxPop, rxFifoClr, txFifoClr, fifoEn, stopBits;
  logic [4:0] rxTrigBytes;
  logic [15:0] divisorOut;
  logic [1:0] wordLen;
  logic [2:0] parityCfg;
  logic [7:0] intEnableOut, modemCtlOut;

  int checks = 0;
  int failures = 0;
  logic [7:0] sRd;
  logic sPush, sPop, sRxClr, sTxClr;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_hostregs dut_i (
    .clk(clk), .rstN(rstN), .csel(csel), .rdStb(rdStb), .wrStb(wrStb),
    .addr(addr), .wrData(wrData), .rdData(rdData), .rxData(RXBUF_V),
    .lineStatus(LSTAT_V), .modemStatus(MSTAT_V), .intIdent(IDENT_V),
    .txPush(txPush), .rxPop(rxPop), .rxFifoClr(rxFifoClr), .txFifoClr(txFifoClr),
    .fifoEn(fifoEn), .rxTrigBytes(rxTrigBytes), .divisorOut(divisorOut),
    .wordLen(wordLen), .stopBits(stopBits), .parityCfg(parityCfg),
    .intEnableOut(intEnableOut), .modemCtlOut(modemCtlOut)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access cycle; strobe outputs sampled before the committing edge
  task automatic access(input logic wr, input logic [2:0] a, input logic [7:0] d,
                        input logic cs = 1'b1);
    @(negedge clk);
    csel = cs; rdStb = ~wr; wrStb = wr; addr = a; wrData = d;
    #2;
    sRd = rdData; sPush = txPush; sPop = rxPop; sRxClr = rxFifoClr; sTxClr = txFifoClr;
    @(posedge clk);
    #1;
    csel = 1'b0; rdStb = 1'b0; wrStb = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic checkResetState(input string tag);
    access(1'b0, 3'd1, 8'h00); check({tag, " ie"}, {8'h0, sRd}, 16'h0);
    access(1'b0, 3'd3, 8'h00); check({tag, " line"}, {8'h0, sRd}, 16'h0);
    access(1'b0, 3'd4, 8'h00); check({tag, " modem"}, {8'h0, sRd}, 16'h0);
    access(1'b0, 3'd7, 8'h00); check({tag, " scratch"}, {8'h0, sRd}, 16'h0);
    access(1'b0, 3'd2, 8'h00); check({tag, " ident"}, {8'h0, sRd}, 16'h0001);
    check({tag, " divisor"}, divisorOut, 16'h0);
    check({tag, " fifoEn"}, {15'h0, fifoEn}, 16'h0);
    check({tag, " trig"}, {11'h0, rxTrigBytes}, 16'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();
    checkResetState("R1 reset");

    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].wr, VECS[i].a, VECS[i].d);
      if (!VECS[i].wr)
        check($sformatf("R%0d vec%0d rdData", VECS[i].req, i), {8'h0, sRd}, {8'h0, VECS[i].exp});
      check($sformatf("R%0d vec%0d push", VECS[i].req, i), {15'h0, sPush}, {15'h0, VECS[i].push});
      check($sformatf("R%0d vec%0d pop", VECS[i].req, i), {15'h0, sPop}, {15'h0, VECS[i].pop});
    end

    // R4 divisor and R3 / R11 outputs
    check("R4 divisorOut", divisorOut, 16'h1234);
    check("R3 intEnableOut", {8'h0, intEnableOut}, 16'h000F);
    check("R11 modemCtlOut", {8'h0, modemCtlOut}, 16'h0013);
    check("R7 fifoEn set", {15'h0, fifoEn}, 16'h1);
    check("R7 trig code 3", {11'h0, rxTrigBytes}, 16'd14);

    // R7 trigger codes and clear pulses
    access(1'b1, 3'd2, 8'h41); check("R7 trig code 1", {11'h0, rxTrigBytes}, 16'd4);
    access(1'b1, 3'd2, 8'h81); check("R7 trig code 2", {11'h0, rxTrigBytes}, 16'd8);
    access(1'b1, 3'd2, 8'h06);
    check("R7 rx clear pulse", {15'h0, sRxClr}, 16'h1);
    check("R7 tx clear pulse", {15'h0, sTxClr}, 16'h1);
    check("R7 trig code 0", {11'h0, rxTrigBytes}, 16'd1);
    check("R7 fifo off", {15'h0, fifoEn}, 16'h0);
    #1;
    check("R7 rx clear ends", {15'h0, rxFifoClr}, 16'h0);
    check("R7 tx clear ends", {15'h0, txFifoClr}, 16'h0);
    access(1'b0, 3'd2, 8'h00); check("R6 back to char mode", {8'h0, sRd}, 16'h0001);

    // R5 line fields
    access(1'b1, 3'd3, 8'h2E);
    check("R5 wordLen", {14'h0, wordLen}, 16'd2);
    check("R5 stopBits", {15'h0, stopBits}, 16'd1);
    check("R5 parityCfg", {13'h0, parityCfg}, 16'd5);
    access(1'b0, 3'd1, 8'h00); check("R5 bank clear reaches ie", {8'h0, sRd}, 16'h000F);

    // R10 strobes without chip select
    access(1'b1, 3'd7, 8'h00, 1'b0);
    check("R10 no push", {15'h0, sPush}, 16'h0);
    access(1'b1, 3'd0, 8'h99, 1'b0);
    check("R10 no push data", {15'h0, sPush}, 16'h0);
    access(1'b0, 3'd0, 8'h00, 1'b0);
    check("R10 rdData zero", {8'h0, sRd}, 16'h0);
    check("R10 no pop", {15'h0, sPop}, 16'h0);
    access(1'b1, 3'd2, 8'h06, 1'b0);
    check("R10 no clear", {14'h0, sRxClr, sTxClr}, 16'h0);
    access(1'b0, 3'd7, 8'h00); check("R10 scratch kept", {8'h0, sRd}, 16'h00A5);

    // R1 reset mid-run
    doReset();
    checkResetState("R1 re-reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule